// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one general-purpose I/O channel of up to sixteen pins, controlled through a simple 32-bit register bus with a word address and a single-cycle write strobe. Software drives pin values through an output data register and selects, pin by pin, whether the pin is driven. It can read back the level seen on every pin after a two-flop synchronizer.

Each pin carries its own interrupt detector. A four-bit mode slot per pin chooses falling edge, rising edge, low level, high level or both edges. A detected event latches a pending flag. Software clears a pending flag by writing a one to it. Pending flags are gated by an enable register and by a mask that has separate set and clear addresses. A single interrupt output reports when any pin is pending, enabled and not masked. A status register shows every pending flag, so the handler can find the source. A soft-reset bit holds all state at its reset values while it is set.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, pin_out and pin_oe are 0, irq_out is 0, and every mode slot holds 0 (falling edge).
- R2: Writing word address 0x0 sets pin_out and writing 0x1 sets pin_oe (1 = driven output). Both take effect in the cycle after the write and read back at the same address.
- R3: Word address 0x2 reads the pin levels delayed by two clock edges. A change driven before edge n is readable after edge n+1 and not after edge n.
- R4: The mode of pin k is the 4-bit slot at bits [4(k mod 8)+3 : 4(k mod 8)] of address 0x4 (pins 0–7) or 0x5 (pins 8–15). The codes are 0 = falling, 1 = rising, 2 = low, 3 = high and 4 = both edges. Slot values 5–15 never raise a pending flag. Slots read back as written.
- R5: In an edge mode, a qualifying pin change driven before edge n sets the pending flag at edge n+2. The flag stays set until cleared.
- R6: In a level mode, the pending flag is set while the synchronized level is active. After a clear it re-asserts on the following edge if the level persists.
- R7: Writing 1s to word address 0x8 clears those pending flags at the write edge. Zero bits leave their flags unchanged, and a clear wins over a trigger in the same cycle.
- R8: Writing 1s to 0x6 sets those mask bits and writing 1s to 0x7 clears them. Zero bits have no effect, and both addresses read back the current mask.
- R9: irq_out is 1 exactly when some pin has pending = 1, enable (address 0x3, read/write) = 1 and mask = 0.
- R10: Word address 0x9 reads the pending flag of pin k at bit k.
- R11: Writing 1 to bit 0 of address 0xA holds all other registers, pending flags and synchronizers at their reset values from the next edge. Other writes are ignored until a 0 is written there, and the bit reads back at 0xA.
- R12: Bits for pins at or above NPINS, and their mode slots, ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Drive enable per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A register write is visible on reads, pin_out, pin_oe and irq_out one nanosecond after the strobed edge. The input readback is due two edges after a pin change, and a pending flag is due three edges after it. The bench drives inputs on the falling clock edge and counts rising edges from there before it samples. For the latency cases it checks one edge early as well as on the due edge. A level-mode re-assertion is checked at the edge after the clear, and the cleared value at the clear edge itself.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MAXP = 16;

  localparam logic [3:0] A_OUT   = 4'h0;
  localparam logic [3:0] A_DIR   = 4'h1;
  localparam logic [3:0] A_IN    = 4'h2;
  localparam logic [3:0] A_IEN   = 4'h3;
  localparam logic [3:0] A_MLO   = 4'h4;
  localparam logic [3:0] A_MHI   = 4'h5;
  localparam logic [3:0] A_MSET  = 4'h6;
  localparam logic [3:0] A_MCLR  = 4'h7;
  localparam logic [3:0] A_PCLR  = 4'h8;
  localparam logic [3:0] A_STAT  = 4'h9;
  localparam logic [3:0] A_SRST  = 4'hA;

  typedef enum logic [3:0] {
    TRG_FALL = 4'd0, TRG_RISE = 4'd1, TRG_LOW = 4'd2,
    TRG_HIGH = 4'd3, TRG_BOTH = 4'd4
  } trg_e;

  // Decide whether a pin fires given its slot code and synchronized samples.
  function automatic logic trig_fire(input logic [3:0] code, input logic cur,
                                     input logic prev);
    case (code)
      TRG_FALL: return prev & ~cur;
      TRG_RISE: return ~prev & cur;
      TRG_LOW:  return ~cur;
      TRG_HIGH: return cur;
      TRG_BOTH: return prev ^ cur;
      default:  return 1'b0;
    endcase
  endfunction

  // Bit mask of the implemented pins.
  function automatic logic [MAXP-1:0] impl_mask(input int n);
    logic [MAXP-1:0] m;
    for (int i = 0; i < MAXP; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NPINS-1:0] din,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prev
);
  logic [NPINS-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else if (clr) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= din;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic [NPINS-1:0][3:0] mode,
  input  logic [NPINS-1:0]      cur,
  input  logic [NPINS-1:0]      prev,
  output logic [NPINS-1:0]      trig
);
  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    assign trig[k] = trig_fire(mode[k], cur[k], prev[k]);
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_out
);
  localparam logic [MAXP-1:0] IMPL = impl_mask(NPINS);

  logic [MAXP-1:0] out_q, dir_q, ien_q, mask_q, pend_q;
  logic [MAXP-1:0][3:0] mode_q;
  logic srst_q;

  // Named internal events for the assertions.
  logic [NPINS-1:0] cur_w, prev_w, trig_w;
  logic [MAXP-1:0]  trig16, wdat16, clr_w, pend_n;
  logic wr_out, wr_dir, wr_ien, wr_mlo, wr_mhi, wr_mset, wr_mclr, wr_pclr, wr_srst;

  assign wdat16  = bus_wdata[MAXP-1:0] & IMPL;
  assign wr_out  = bus_wr && !srst_q && bus_addr == A_OUT;
  assign wr_dir  = bus_wr && !srst_q && bus_addr == A_DIR;
  assign wr_ien  = bus_wr && !srst_q && bus_addr == A_IEN;
  assign wr_mlo  = bus_wr && !srst_q && bus_addr == A_MLO;
  assign wr_mhi  = bus_wr && !srst_q && bus_addr == A_MHI;
  assign wr_mset = bus_wr && !srst_q && bus_addr == A_MSET;
  assign wr_mclr = bus_wr && !srst_q && bus_addr == A_MCLR;
  assign wr_pclr = bus_wr && !srst_q && bus_addr == A_PCLR;
  assign wr_srst = bus_wr && bus_addr == A_SRST;

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .din(pin_in),
    .cur(cur_w), .prev(prev_w)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_det (
    .mode(mode_q[NPINS-1:0]), .cur(cur_w), .prev(prev_w), .trig(trig_w)
  );

  assign trig16 = MAXP'(trig_w);
  assign clr_w  = wr_pclr ? wdat16 : '0;
  assign pend_n = (pend_q | trig16) & ~clr_w & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
    end else if (wr_srst) begin
      srst_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      mode_q <= '0;
    end else if (srst_q) begin
      out_q  <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_out)  out_q <= wdat16;
      if (wr_dir)  dir_q <= wdat16;
      if (wr_ien)  ien_q <= wdat16;
      if (wr_mset) mask_q <= mask_q | wdat16;
      else if (wr_mclr) mask_q <= mask_q & ~wdat16;
      pend_q <= pend_n;
      for (int j = 0; j < MAXP; j++) begin
        if (IMPL[j]) begin
          if (j < 8 && wr_mlo) mode_q[j] <= bus_wdata[4*(j%8) +: 4];
          if (j >= 8 && wr_mhi) mode_q[j] <= bus_wdata[4*(j%8) +: 4];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_OUT:  bus_rdata = 32'(out_q);
      A_DIR:  bus_rdata = 32'(dir_q);
      A_IN:   bus_rdata = 32'(cur_w);
      A_IEN:  bus_rdata = 32'(ien_q);
      A_MLO:  for (int j = 0; j < 8; j++) bus_rdata[4*j +: 4] = mode_q[j];
      A_MHI:  for (int j = 0; j < 8; j++) bus_rdata[4*j +: 4] = mode_q[j+8];
      A_MSET, A_MCLR: bus_rdata = 32'(mask_q);
      A_STAT: bus_rdata = 32'(pend_q);
      A_SRST: bus_rdata = {31'd0, srst_q};
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q[NPINS-1:0];
  assign pin_oe  = dir_q[NPINS-1:0];
  assign irq_out = |(pend_q & ien_q & ~mask_q);

  // A pending flag only rises after its detector fired in the previous cycle.
  assert_pend_needs_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~$past(trig16)) == '0);

  // Flags named in a clear write are low after the write edge.
  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !srst_q && bus_addr == A_PCLR) |=>
      ((pend_q & $past(bus_wdata[MAXP-1:0]) & IMPL) == '0));

  // Bits named in a mask-set write are set after the write edge.
  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !srst_q && bus_addr == A_MSET) |=>
      ((mask_q & $past(wdat16)) == $past(wdat16)));

  // While soft reset is held, state is back at its defaults one edge later.
  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (pend_q == '0 && ien_q == '0 && out_q == '0 && dir_q == '0
                && mask_q == '0));

  // Unimplemented status bits read zero.
  assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT) |-> (bus_rdata[31:NPINS] == '0));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  localparam int CLK_P = 10;
  localparam int NP    = 12;
  localparam logic [31:0] PM = (32'd1 << NP) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_port #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  // Mode words with every slot inert (7) except one pin given code c.
  function automatic logic [31:0] slot_word(input int pin, input int c, input bit hi);
    logic [31:0] w = 32'h7777_7777;
    if ((pin >= 8) == hi) w[4*(pin%8) +: 4] = 4'(c);
    return w;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0A5C;
    pats[2] = 32'h1234_5963; pats[3] = 32'h0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    edges(1);

    // R1 reset state
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), d); chk($sformatf("R1 reset read addr %0d", a), d, 32'h0);
    end
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 irq_out", 32'(irq_out), 0);

    // R2 / R12 output and direction registers
    for (int p = 0; p < 4; p++) begin
      wr(4'h0, pats[p]);
      chk("R2 pin_out", 32'(pin_out), pats[p] & PM);
      rd(4'h0, d); chk("R12 OUT readback", d, pats[p] & PM);
      wr(4'h1, ~pats[p]);
      chk("R2 pin_oe", 32'(pin_oe), ~pats[p] & PM);
      rd(4'h1, d); chk("R12 DIR readback", d, ~pats[p] & PM);
      wr(4'h3, pats[p]);
      rd(4'h3, d); chk("R12 IEN readback", d, pats[p] & PM);
    end
    wr(4'h3, 0); wr(4'h1, 0);
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, d); chk("R4 mode low readback", d, 32'hFFFF_FFFF);
    wr(4'h5, 32'hFFFF_FFFF); rd(4'h5, d); chk("R12 mode high readback", d, 32'h0000_FFFF);
    wr(4'h5, 32'h1234_5678); rd(4'h5, d); chk("R4 mode high readback", d, 32'h0000_5678);

    // R3 input synchronizer latency
    begin
      logic [NP-1:0] prevp = '0;
      for (int p = 1; p < 4; p++) begin
        drive(NP'(pats[p]));
        edges(1); rd(4'h2, d); chk("R3 IN one edge early", d, 32'(prevp));
        edges(1); rd(4'h2, d); chk("R3 IN after two edges", d, pats[p] & PM);
        prevp = NP'(pats[p]);
      end
    end
    edges(3);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h9, d); chk("R7 clear all", d, 0);

    // R5 edge latency, pin 0 rising
    wr(4'h4, slot_word(0, 1, 0)); wr(4'h5, 32'h7777_7777);
    drive(12'h001);
    edges(2); rd(4'h9, d); chk("R5 pending not yet at edge 2", d, 0);
    edges(1); rd(4'h9, d); chk("R5 pending at edge 3", d, 1);
    drive(12'h000); edges(4);
    wr(4'h8, 32'hFFF);

    // R4 R5 R6 R10 sweep over every pin and every slot code
    for (int k = 0; k < NP; k++) begin
      for (int c = 0; c < 8; c++) begin
        bit lo, hi, ed_r, ed_f;
        lo = (c == 2); hi = (c == 3);
        ed_r = (c == 1 || c == 4); ed_f = (c == 0 || c == 4);
        wr(4'h4, slot_word(k, c, 0));
        wr(4'h5, slot_word(k, c, 1));
        edges(4);
        wr(4'h8, 32'hFFF);
        rd(4'h9, d); chk($sformatf("R7 cleared pin %0d code %0d", k, c), d, 0);
        edges(1); rd(4'h9, d);
        chk($sformatf("R6 low re-assert pin %0d code %0d", k, c), d, 32'(lo) << k);
        drive(NP'(1) << k); edges(4); rd(4'h9, d);
        chk($sformatf("R5 rise pin %0d code %0d", k, c), d, 32'(ed_r || lo || hi) << k);
        wr(4'h8, 32'(1) << k);
        rd(4'h9, d); chk($sformatf("R7 clear wins pin %0d code %0d", k, c), d, 0);
        edges(1); rd(4'h9, d);
        chk($sformatf("R6 high re-assert pin %0d code %0d", k, c), d, 32'(hi) << k);
        drive('0); edges(4); rd(4'h9, d);
        chk($sformatf("R10 fall pin %0d code %0d", k, c), d, 32'(ed_f || lo || hi) << k);
        wr(4'h8, 32'(1) << k);
        edges(1); rd(4'h9, d);
        chk($sformatf("R6 low again pin %0d code %0d", k, c), d, 32'(lo) << k);
      end
    end
    wr(4'h4, 32'h7777_7777); wr(4'h5, 32'h7777_7777);
    edges(2); wr(4'h8, 32'hFFF);

    // R9 interrupt gating
    wr(4'h4, slot_word(0, 1, 0));
    drive(12'h001); edges(4);
    rd(4'h9, d); chk("R10 status pin 0", d, 1);
    chk("R9 irq off when disabled", 32'(irq_out), 0);
    wr(4'h3, 1); chk("R9 irq on when enabled", 32'(irq_out), 1);
    wr(4'h6, 1); chk("R9 irq off when masked", 32'(irq_out), 0);
    wr(4'h7, 1); chk("R9 irq on when unmasked", 32'(irq_out), 1);
    wr(4'h8, 1); chk("R9 irq off after clear", 32'(irq_out), 0);
    drive(12'h000); edges(2);

    // R7 zero bits leave other flags
    wr(4'h4, 32'h7777_1771);
    drive(12'h009); edges(4);
    rd(4'h9, d); chk("R10 two pins pending", d, 32'h9);
    wr(4'h8, 32'h1);
    rd(4'h9, d); chk("R7 zero bits no effect", d, 32'h8);
    edges(1); rd(4'h9, d); chk("R7 flag 3 held", d, 32'h8);
    wr(4'h8, 32'h8); rd(4'h9, d); chk("R7 flag 3 cleared", d, 0);
    drive(12'h000); edges(3);

    // R8 mask set and clear
    wr(4'h6, 32'hFFFF_FA5A); rd(4'h6, d); chk("R8 mask set", d, 32'hA5A);
    wr(4'h6, 0); rd(4'h7, d); chk("R8 zero set no effect", d, 32'hA5A);
    wr(4'h7, 32'h00A); rd(4'h6, d); chk("R8 mask clear", d, 32'hA50);
    wr(4'h7, 0); rd(4'h7, d); chk("R8 zero clear no effect", d, 32'hA50);
    wr(4'h7, 32'hFFFF_FFFF); rd(4'h6, d); chk("R8 mask all clear", d, 0);

    // R11 soft reset
    wr(4'h0, 32'h123); wr(4'h1, 32'h0F0); wr(4'h3, 32'h3); wr(4'h6, 32'h5);
    wr(4'h4, 32'h1111_1111);
    drive(12'h001); edges(4);
    rd(4'h9, d); chk("R11 pending before soft reset", d, 1);
    wr(4'hA, 1);
    rd(4'hA, d); chk("R11 soft reset bit", d, 1);
    edges(1);
    rd(4'h0, d); chk("R11 OUT cleared", d, 0);
    rd(4'h1, d); chk("R11 DIR cleared", d, 0);
    rd(4'h3, d); chk("R11 IEN cleared", d, 0);
    rd(4'h6, d); chk("R11 mask cleared", d, 0);
    rd(4'h4, d); chk("R11 mode cleared", d, 0);
    rd(4'h9, d); chk("R11 pending cleared", d, 0);
    rd(4'h2, d); chk("R11 input sync cleared", d, 0);
    chk("R11 pin_out cleared", 32'(pin_out), 0);
    wr(4'h0, 32'hFF); rd(4'h0, d); chk("R11 write ignored while held", d, 0);
    wr(4'hA, 0); rd(4'hA, d); chk("R11 release", d, 0);
    wr(4'h0, 32'h55); rd(4'h0, d); chk("R11 write after release", d, 32'h55);

    summary();
  end
endmodule